// File: doc/BRIEF.md
# Multichannel Conversion-Result Serializer

This block gathers the 10-bit results of eight converter channels and hands them to the back end in one of three run-time modes. In parallel test mode, the latest word of one chosen channel is held on a 10-bit bus. In lane mode, every channel with a fresh word shifts it out on its own serial line, and all eight lines run side by side. In full mode, the words of all eight channels are chained into one 80-bit stream on a single serial line.

Everything runs on the fast bit clock. A free-running bit counter defines frames. A frame is 10 bit-clock cycles in test and lane modes and 80 cycles in full mode. At each frame boundary the block samples the mode and channel-select inputs. It also moves every pending channel word from its holding register into a shadow shift register. This lets the next sample arrive while the current one is still being sent. A per-channel sticky flag records a word that was replaced before it could be sent.

Top module: `adc_ser_top`

## Requirements
- R1: While reset is held and after its release, all serial lines, both frame-marker outputs, the test bus and the overrun flags are 0, and the block starts in test mode with channel 0 selected.
- R2: In test mode, at a frame boundary where the channel named by `chanSel` has a pending word, `testBus` takes that word. `testBus` then holds it while words arrive on other channels. In lane and full modes `testBus` reads 0.
- R3: In lane mode (`modeSel` = 01), each channel that had a pending word at the boundary sends it on `laneOut[c]`, most significant bit first, one bit per clock, for 10 clocks. All lanes send in the same cycles.
- R4: In full mode (`modeSel` = 10), `fullOut` carries an 80-bit frame: channel 0's word first, then channels 1 through 7 in ascending order, each word most significant bit first. A channel with no pending word contributes zeros.
- R5: `laneFrame[c]` is high only in the cycle that carries the first bit of a lane-mode frame on lane c, and only when that lane had data. `fullFrame` is high only in the cycle carrying bit 0 of a full frame that has at least one pending word. Lanes without data stay low and have no marker.
- R6: Changes on `modeSel` and `chanSel` take effect only at the next frame boundary. A frame already in flight finishes in the mode it started with.
- R7: A second strobe on a channel whose word is still pending (not yet moved to the shadow register at a boundary) sets that channel's sticky `overrun` bit. The newer word replaces the older one. Only reset clears the bit.
- R8: `laneOut` is all-zero outside lane mode, and `fullOut` is 0 outside full mode.
- R9: `modeSel` code 11 behaves exactly as test mode (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Mode request: 00 test, 01 lane, 10 full, 11 test |
| chanSel | input | 3 | Channel shown on the test bus |
| sampleValid | input | 8 | Per-channel word strobe |
| sampleData | input | 80 | Channel words, channel c in bits [10c+9:10c] |
| testBus | output | 10 | Parallel word of the selected channel |
| laneOut | output | 8 | Per-channel serial lines |
| laneFrame | output | 8 | First-bit marker per lane |
| fullOut | output | 1 | Combined serial line |
| fullFrame | output | 1 | First-bit marker of the combined line |
| overrun | output | 8 | Sticky per-channel replaced-word flags |

## Verification
The bench changes the mode in the middle of a full frame. A design that switched modes at once would truncate the 80-bit stream or start lane markers early. It sends back-to-back strobes on one channel within a frame and checks both the overrun flag and that the second word is the one sent. A design that kept the first word, or flagged channels that were strobed once, fails this check. The full-mode stream is compared bit for bit against channel 0..7, MSB-first order, which catches reversed channel or bit order. Code 11 and strobes on unselected channels are driven in test mode to catch a test bus that follows the wrong channel or ignores the fallback decode.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef enum logic [1:0] {
    MODE_TEST = 2'b00,
    MODE_LANE = 2'b01,
    MODE_FULL = 2'b10
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic boundary;   // last bit of current frame; next edge starts a frame
    logic firstBit;   // current cycle carries bit 0 of a frame
    logic testMode;   // active mode flags
    logic laneMode;
    logic fullMode;
    logic nextTest;   // mode the next frame will run in
    logic nextLane;
    logic nextFull;
  } ctrl_t;

endpackage

// File: rtl/adc_ser_ctrl.sv
module adc_ser_ctrl
  import adc_ser_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int NUM_CH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] modeSel,
  output ctrl_t      ctrl
);
  localparam int FULL_LEN = WORD_W * NUM_CH;
  localparam int CNT_W = $clog2(FULL_LEN);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_LEN - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  mode_e activeMode;
  mode_e nextMode;
  logic boundary;

  // code 11 falls back to test mode
  always_comb begin
    case (modeSel)
      2'b01:   nextMode = MODE_LANE;
      2'b10:   nextMode = MODE_FULL;
      default: nextMode = MODE_TEST;
    endcase
  end

  assign lastIdx  = (activeMode == MODE_FULL) ? FULL_LAST : WORD_LAST;
  assign boundary = (bitCnt == lastIdx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt     <= WORD_LAST;
      activeMode <= MODE_TEST;
    end else if (boundary) begin
      bitCnt     <= '0;
      activeMode <= nextMode;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.boundary = boundary;
    ctrl.firstBit = (bitCnt == '0);
    ctrl.testMode = (activeMode == MODE_TEST);
    ctrl.laneMode = (activeMode == MODE_LANE);
    ctrl.fullMode = (activeMode == MODE_FULL);
    ctrl.nextTest = (nextMode == MODE_TEST);
    ctrl.nextLane = (nextMode == MODE_LANE);
    ctrl.nextFull = (nextMode == MODE_FULL);
  end

endmodule

// File: rtl/adc_ser_datapath.sv
module adc_ser_datapath
  import adc_ser_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int NUM_CH = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t                    ctrl,
  input  logic [SEL_W-1:0]         chanSel,
  input  logic [NUM_CH-1:0]        sampleValid,
  input  logic [NUM_CH*WORD_W-1:0] sampleData,
  output logic [WORD_W-1:0]        testBus,
  output logic [NUM_CH-1:0]        laneOut,
  output logic [NUM_CH-1:0]        laneFrame,
  output logic                     fullOut,
  output logic                     fullFrame,
  output logic [NUM_CH-1:0]        overrun
);
  logic [NUM_CH-1:0][WORD_W-1:0] holdReg;
  logic [NUM_CH-1:0][WORD_W-1:0] shadowReg;
  logic [NUM_CH-1:0]             pending;
  logic [NUM_CH-1:0]             laneLive;
  logic [NUM_CH-1:0]             chainIn;
  logic                          fullLive;
  logic [WORD_W-1:0]             testReg;
  logic                          nextSerial;

  assign nextSerial = ctrl.nextLane | ctrl.nextFull;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // full-mode chain: channel c takes the MSB of channel c+1
    if (c < NUM_CH - 1) begin : g_link
      assign chainIn[c] = shadowReg[c+1][WORD_W-1];
    end else begin : g_tail
      assign chainIn[c] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        holdReg[c] <= '0;
        pending[c] <= 1'b0;
        overrun[c] <= 1'b0;
      end else begin
        if (sampleValid[c]) begin
          holdReg[c] <= sampleData[c*WORD_W +: WORD_W];
          pending[c] <= 1'b1;
          if (pending[c] && !ctrl.boundary) overrun[c] <= 1'b1;
        end else if (ctrl.boundary) begin
          pending[c] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadowReg[c] <= '0;
        laneLive[c]  <= 1'b0;
      end else if (ctrl.boundary) begin
        shadowReg[c] <= (nextSerial && pending[c]) ? holdReg[c] : '0;
        laneLive[c]  <= ctrl.nextLane && pending[c];
      end else if (ctrl.laneMode) begin
        shadowReg[c] <= {shadowReg[c][WORD_W-2:0], 1'b0};
      end else if (ctrl.fullMode) begin
        shadowReg[c] <= {shadowReg[c][WORD_W-2:0], chainIn[c]};
      end
    end

    assign laneOut[c]   = ctrl.laneMode & shadowReg[c][WORD_W-1];
    assign laneFrame[c] = ctrl.laneMode & ctrl.firstBit & laneLive[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fullLive <= 1'b0;
      testReg  <= '0;
    end else if (ctrl.boundary) begin
      fullLive <= ctrl.nextFull && (|pending);
      if (ctrl.nextTest && pending[chanSel]) testReg <= holdReg[chanSel];
    end
  end

  assign fullOut   = ctrl.fullMode & shadowReg[0][WORD_W-1];
  assign fullFrame = ctrl.fullMode & ctrl.firstBit & fullLive;
  assign testBus   = ctrl.testMode ? testReg : '0;

endmodule

// File: rtl/adc_ser_top.sv
module adc_ser_top
  import adc_ser_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int NUM_CH = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               modeSel,
  input  logic [SEL_W-1:0]         chanSel,
  input  logic [NUM_CH-1:0]        sampleValid,
  input  logic [NUM_CH*WORD_W-1:0] sampleData,
  output logic [WORD_W-1:0]        testBus,
  output logic [NUM_CH-1:0]        laneOut,
  output logic [NUM_CH-1:0]        laneFrame,
  output logic                     fullOut,
  output logic                     fullFrame,
  output logic [NUM_CH-1:0]        overrun
);
  ctrl_t ctrl;

  adc_ser_ctrl #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .modeSel (modeSel),
    .ctrl    (ctrl)
  );

  adc_ser_datapath #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .chanSel     (chanSel),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .testBus     (testBus),
    .laneOut     (laneOut),
    .laneFrame   (laneFrame),
    .fullOut     (fullOut),
    .fullFrame   (fullFrame),
    .overrun     (overrun)
  );

endmodule

// File: rtl/adc_ser_checker.sv
module adc_ser_checker #(
  parameter int WORD_W = 10,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] sampleValid,
  input logic [WORD_W-1:0] testBus,
  input logic [NUM_CH-1:0] laneOut,
  input logic [NUM_CH-1:0] laneFrame,
  input logic              fullOut,
  input logic              fullFrame,
  input logic [NUM_CH-1:0] overrun
);
  AST_FULL_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fullFrame |-> (laneOut == '0)); // R8

  AST_TEST_SERIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (testBus != '0) |-> ((laneOut == '0) && !fullOut)); // R2

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((overrun & $past(overrun)) == $past(overrun))); // R7

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(overrun & ~$past(overrun))) |-> (|$past(sampleValid))); // R7

  AST_LANE_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|laneFrame) |=> (laneFrame == '0)); // R5

  AST_FULL_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fullFrame |=> !fullFrame); // R5

  AST_MARK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fullFrame |-> (laneFrame == '0)); // R5

endmodule

bind adc_ser_top adc_ser_checker #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sampleValid (sampleValid),
  .testBus     (testBus),
  .laneOut     (laneOut),
  .laneFrame   (laneFrame),
  .fullOut     (fullOut),
  .fullFrame   (fullFrame),
  .overrun     (overrun)
);

// File: tb/adc_ser_top_tb.sv
module adc_ser_top_tb;
  localparam int W = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic [2:0]   chanSel = 3'd0;
  logic [N-1:0] sampleValid = '0;
  logic [N*W-1:0] sampleData = '0;
  logic [W-1:0] testBus;
  logic [N-1:0] laneOut, laneFrame, overrun;
  logic         fullOut, fullFrame;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_ser_top u_dut (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .chanSel(chanSel),
    .sampleValid(sampleValid), .sampleData(sampleData), .testBus(testBus),
    .laneOut(laneOut), .laneFrame(laneFrame), .fullOut(fullOut),
    .fullFrame(fullFrame), .overrun(overrun)
  );

  // {modeCode, channel, word}
  typedef struct packed { logic [1:0] code; logic [2:0] ch; logic [W-1:0] word; } vec_t;
  localparam vec_t TEST_VECS [6] = '{
    '{2'b00, 3'd0, 10'h2A5},
    '{2'b00, 3'd3, 10'h13C},
    '{2'b11, 3'd6, 10'h3FF},
    '{2'b00, 3'd7, 10'h001},
    '{2'b11, 3'd1, 10'h200},
    '{2'b00, 3'd5, 10'h155}
  };

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] mask, input logic [N*W-1:0] data);
    @(negedge clk);
    sampleValid = mask;
    sampleData  = data;
    @(negedge clk);
    sampleValid = '0;
  endtask

  function automatic logic [N*W-1:0] pack(input logic [W-1:0] w [N]);
    logic [N*W-1:0] r;
    for (int c = 0; c < N; c++) r[c*W +: W] = w[c];
    return r;
  endfunction

  logic [W-1:0] words [N];
  logic [W-1:0] got [N];
  logic [79:0]  fullGot, fullExp;
  bit           lanesQuiet;

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(testBus == 0 && laneOut == 0 && !fullOut && laneFrame == 0 && !fullFrame && overrun == 0,
        "R1 outputs in reset", {testBus, laneOut, overrun}, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(testBus == 0 && laneOut == 0 && !fullOut && overrun == 0,
        "R1 outputs after reset", {testBus, laneOut, overrun}, 0);

    // R2 / R9 test mode table
    for (int v = 0; v < 6; v++) begin
      vec_t tv = TEST_VECS[v];
      int k;
      modeSel = tv.code;
      chanSel = tv.ch;
      repeat (12) @(negedge clk);
      pulse(8'b1 << tv.ch, {N{tv.word}});
      for (k = 0; k < 30 && testBus != tv.word; k++) @(negedge clk);
      chk(testBus == tv.word, tv.code == 2'b11 ? "R9 code 11 test bus" : "R2 test bus word",
          testBus, tv.word);
      pulse(8'b1 << (tv.ch ^ 3'd1), {N{~tv.word}});
      repeat (25) @(negedge clk);
      chk(testBus == tv.word, "R2 unselected strobe ignored", testBus, tv.word);
      chk(laneOut == 0 && !fullOut, "R8 serial quiet in test", {laneOut, fullOut}, 0);
    end

    // R3 lane mode
    modeSel = 2'b01;
    repeat (12) @(negedge clk);
    chk(testBus == 0, "R2 test bus zero in lane mode", testBus, 0);
    for (int c = 0; c < N; c++) words[c] = W'(10'h0A3 * (c + 1) + 10'h111 * c);
    pulse('1, pack(words));
    for (int k = 0; k < 30 && laneFrame == 0; k++) @(negedge clk);
    chk(laneFrame == 8'hFF, "R5 lane markers together", laneFrame, 8'hFF);
    for (int c = 0; c < N; c++) got[c] = '0;
    for (int b = 0; b < W; b++) begin
      if (b > 0) begin
        @(negedge clk);
        if (laneFrame != 0) chk(1'b0, "R5 lane marker mid word", laneFrame, 0);
      end
      for (int c = 0; c < N; c++) got[c] = {got[c][W-2:0], laneOut[c]};
    end
    for (int c = 0; c < N; c++) chk(got[c] == words[c], "R3 lane word msb first", got[c], words[c]);
    @(negedge clk);
    chk(laneOut == 0 && laneFrame == 0, "R5 idle lane after word", {laneOut, laneFrame}, 0);
    chk(overrun == 0, "R7 single strobes no overrun", overrun, 0);
    chk(!fullOut, "R8 full line quiet in lane mode", fullOut, 0);

    // R4 full mode
    modeSel = 2'b10;
    repeat (12) @(negedge clk);
    for (int c = 0; c < N; c++) words[c] = W'(10'h35A ^ (10'h47 * c));
    pulse('1, pack(words));
    for (int k = 0; k < 100 && !fullFrame; k++) @(negedge clk);
    chk(fullFrame, "R5 full marker", fullFrame, 1);
    fullExp = '0;
    for (int c = 0; c < N; c++) fullExp = {fullExp[69:0], words[c]};
    fullGot = '0;
    lanesQuiet = 1'b1;
    for (int b = 0; b < 80; b++) begin
      if (b > 0) @(negedge clk);
      fullGot = {fullGot[78:0], fullOut};
      if (laneOut != 0) lanesQuiet = 1'b0;
    end
    chk(fullGot == fullExp, "R4 full frame order", fullGot, fullExp);
    chk(lanesQuiet, "R8 lanes quiet in full mode", lanesQuiet, 1);

    // R7 overrun and replacement, R6 mode change mid frame
    @(negedge clk);
    for (int c = 0; c < N; c++) words[c] = W'(10'h1C7 + 10'h59 * c);
    sampleData = pack(words);
    sampleValid = '1;
    @(negedge clk);
    words[3] = 10'h2E1;
    sampleData = pack(words);
    sampleValid = 8'h08;
    @(negedge clk);
    sampleValid = '0;
    chk(overrun == 8'h08, "R7 overrun on channel 3 only", overrun, 8'h08);
    for (int k = 0; k < 100 && !fullFrame; k++) @(negedge clk);
    fullExp = '0;
    for (int c = 0; c < N; c++) fullExp = {fullExp[69:0], words[c]};
    fullGot = '0;
    for (int b = 0; b < 80; b++) begin
      if (b > 0) @(negedge clk);
      if (b == 5) modeSel = 2'b01;
      fullGot = {fullGot[78:0], fullOut};
    end
    chk(fullGot == fullExp, "R6 R7 frame completes with newer word", fullGot, fullExp);
    repeat (6) @(negedge clk);
    chk(!fullOut && !fullFrame && testBus == 0, "R6 lane mode after boundary",
        {fullOut, fullFrame, testBus}, 0);
    chk(overrun == 8'h08, "R7 overrun sticky", overrun, 8'h08);

    // R1 reset again clears flags
    rst_n = 1'b0;
    @(negedge clk);
    chk(overrun == 0 && testBus == 0 && laneOut == 0, "R1 reset clears",
        {overrun, testBus, laneOut}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule